// File: doc/BRIEF.md
# Pixel Bias Threshold and Parity Unit

The unit sits in the pixel acquisition path of an imaging front end. It takes one 12-bit pixel per valid cycle, together with the 16-bit bias map entry for that pixel and the pixel's column number. It checks the odd parity of the bias entry. It subtracts the bias from the pixel in signed arithmetic and compares the difference against a signed threshold. There are four threshold registers, and the top two column bits pick which one applies.

Each comparison yields one threshold bit. The bits are packed into 32-bit words so that software can scan the threshold plane 32 pixels at a time. Capture is decided per frame by a one-shot arm flag. A frame that begins while the flag is set is captured, and the flag clears itself. A frame that begins while the flag is clear is dropped entirely.

Top module: `pix_thresh_unit`

## Requirements
- R1: After reset, `armed_o`, `perr_o` and `word_valid_o` are 0, and all four thresholds are 0.
- R2: A pixel's threshold bit is 1 only when (pixel minus bias bits 11:0) is strictly greater than the selected threshold. The subtraction and the comparison use 14-bit two's complement, so negative differences and negative thresholds compare correctly.
- R3: Column bits 9:8 select the threshold register. A write with `thr_we_i` stores `thr_data_i` into register `thr_sel_i` at the clock edge. Pixels accepted after that edge see the new value.
- R4: A bias word is in error when the count of ones in bits 12:0 is even, or when bit 15 is set. Bits 14:13 are ignored.
- R5: An error on a captured pixel sets the sticky `perr_o`. A `perr_clr_i` pulse clears it, but a new error in the same cycle wins. The failing pixel still produces its threshold bit.
- R6: A frame starts on a cycle with `pix_valid_i` and `frame_start_i` both high. If the arm flag is set at that point, the frame is captured and the flag clears. Otherwise every pixel of the frame is discarded: no words are emitted and no parity errors are raised.
- R7: An `arm_set_i` pulse sets the arm flag. When it arrives in the same cycle as a frame start, the current frame is decided by the old flag value, and the pulse arms the following frame.
- R8: Threshold bits pack least significant bit first. `word_valid_o` pulses for one cycle in the cycle after the 32nd captured pixel, with the word on `word_data_o`. A frame start discards any partial word.
- R9: Cycles with `pix_valid_i` low are ignored whatever the other pixel inputs carry, including `frame_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel inputs are valid this cycle |
| frame_start_i | input | 1 | Marks the first pixel of a frame |
| pix_data_i | input | 12 | Pixel value |
| pix_col_i | input | 10 | Column of the pixel |
| bias_word_i | input | 16 | Bias map entry: bias 11:0, parity 12, error 15 |
| arm_set_i | input | 1 | Arms capture of the next frame |
| thr_we_i | input | 1 | Threshold register write enable |
| thr_sel_i | input | 2 | Threshold register index |
| thr_data_i | input | 14 | Threshold value, two's complement |
| perr_clr_i | input | 1 | Clears the sticky parity error |
| armed_o | output | 1 | Arm flag state |
| perr_o | output | 1 | Sticky parity error |
| word_valid_o | output | 1 | Packed word strobe |
| word_data_o | output | 32 | Packed threshold bits |

## Verification
The bench drives differences equal to the threshold and one above it, for both positive and negative thresholds. An off-by-one or an unsigned comparison therefore shows up as flipped bits in a known pattern. It sends bias words whose only fault is the stored parity bit or the error bit, and words with junk in bits 14:13. It clears the error in the same cycle as a new fault, which catches inverted parity, missing error-bit handling and wrong clear priority.

It also covers frame gating. It issues an arm pulse together with the start of a dropped frame. It restarts a captured frame partway through a word, and it asserts a stray frame start while the pixel is invalid. A design that mishandles any of these emits extra or shifted words, or leaves the arm flag in the wrong state.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int BIAS_W       = 16;
  localparam int BIAS_PAR_BIT = 12;
  localparam int BIAS_ERR_BIT = 15;

  typedef enum logic {
    FR_DROP = 1'b0,
    FR_KEEP = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/pt_thr_bank.sv
module pt_thr_bank #(
  parameter int THR_W = 14,
  parameter int GRP_N = 4,
  parameter int SEL_W = $clog2(GRP_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic [THR_W-1:0] wdata_i,
  input  logic [SEL_W-1:0] rsel_i,
  output logic [THR_W-1:0] rdata_o
);
  logic [GRP_N-1:0][THR_W-1:0] regs_w;

  for (genvar g = 0; g < GRP_N; g++) begin : g_reg
    logic [THR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (we_i && wsel_i == SEL_W'(g))    q <= wdata_i;
    end
    assign regs_w[g] = q;
  end

  assign rdata_o = regs_w[rsel_i];
endmodule

// File: rtl/pt_pix_eval.sv
module pt_pix_eval import pt_pkg::*; #(
  parameter int PIX_W = 12,
  parameter int THR_W = 14
) (
  input  logic              [PIX_W-1:0]  pix_i,
  input  logic              [BIAS_W-1:0] bias_word_i,
  input  logic signed       [THR_W-1:0]  thr_i,
  output logic                           above_o,
  output logic                           perr_o
);
  logic signed [THR_W-1:0] pix_s, bias_s, diff_s;
  logic odd_ok;
  logic unused_bits;

  assign pix_s  = $signed(THR_W'(pix_i));
  assign bias_s = $signed(THR_W'(bias_word_i[PIX_W-1:0]));
  assign diff_s = pix_s - bias_s;
  assign above_o = diff_s > thr_i;

  assign odd_ok = ^{bias_word_i[BIAS_PAR_BIT], bias_word_i[PIX_W-1:0]};
  assign perr_o = ~odd_ok | bias_word_i[BIAS_ERR_BIT];

  assign unused_bits = ^bias_word_i[BIAS_ERR_BIT-1:BIAS_PAR_BIT+1];
endmodule

// File: rtl/pt_frame_gate.sv
module pt_frame_gate import pt_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pix_valid_i,
  input  logic frame_start_i,
  input  logic arm_set_i,
  output logic capt_now_o,
  output logic start_o,
  output logic armed_o
);
  logic        armed_q;
  frame_mode_e mode_q;

  assign start_o    = pix_valid_i & frame_start_i;
  assign capt_now_o = pix_valid_i & (start_o ? armed_q : (mode_q == FR_KEEP));
  assign armed_o    = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= FR_DROP;
    end else if (start_o) begin
      mode_q  <= armed_q ? FR_KEEP : FR_DROP;
      armed_q <= arm_set_i;          // one-shot: consumed here, re-armed only by a fresh pulse
    end else if (arm_set_i) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pt_bit_packer.sv
module pt_bit_packer #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q, idx;
  logic [WORD_W-1:0] acc_q, acc_n;
  logic              last;

  always_comb begin
    idx        = restart_i ? '0 : cnt_q;
    acc_n      = acc_q;
    acc_n[idx] = bit_i;
    last       = (idx == CNT_W'(WORD_W-1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      acc_q        <= '0;
      word_valid_o <= 1'b0;
      word_o       <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (bit_valid_i) begin
        acc_q <= acc_n;
        if (last) begin
          word_valid_o <= 1'b1;
          word_o       <= acc_n;
          cnt_q        <= '0;
        end else begin
          cnt_q <= idx + 1'b1;
        end
      end else if (restart_i) begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pix_thresh_unit.sv
module pix_thresh_unit import pt_pkg::*; #(
  parameter int PIX_W  = 12,
  parameter int THR_W  = 14,
  parameter int COL_W  = 10,
  parameter int GRP_N  = 4,
  parameter int SEL_W  = $clog2(GRP_N),
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_valid_i,
  input  logic              frame_start_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic [COL_W-1:0]  pix_col_i,
  input  logic [BIAS_W-1:0] bias_word_i,
  input  logic              arm_set_i,
  input  logic              thr_we_i,
  input  logic [SEL_W-1:0]  thr_sel_i,
  input  logic [THR_W-1:0]  thr_data_i,
  input  logic              perr_clr_i,
  output logic              armed_o,
  output logic              perr_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o
);
  logic [SEL_W-1:0] grp;
  logic [THR_W-1:0] thr_cur;
  logic             above, pix_perr, capt_now, start;
  logic             perr_q;
  logic             unused_col;

  assign grp        = pix_col_i[COL_W-1 -: SEL_W];
  assign unused_col = ^pix_col_i[COL_W-SEL_W-1:0];

  pt_thr_bank #(.THR_W(THR_W), .GRP_N(GRP_N), .SEL_W(SEL_W)) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (thr_we_i),
    .wsel_i  (thr_sel_i),
    .wdata_i (thr_data_i),
    .rsel_i  (grp),
    .rdata_o (thr_cur)
  );

  pt_pix_eval #(.PIX_W(PIX_W), .THR_W(THR_W)) u_eval (
    .pix_i       (pix_data_i),
    .bias_word_i (bias_word_i),
    .thr_i       (thr_cur),
    .above_o     (above),
    .perr_o      (pix_perr)
  );

  pt_frame_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pix_valid_i   (pix_valid_i),
    .frame_start_i (frame_start_i),
    .arm_set_i     (arm_set_i),
    .capt_now_o    (capt_now),
    .start_o       (start),
    .armed_o       (armed_o)
  );

  pt_bit_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (start),
    .bit_valid_i  (capt_now),
    .bit_i        (above),
    .word_valid_o (word_valid_o),
    .word_o       (word_data_o)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   perr_q <= 1'b0;
    else if (capt_now && pix_perr) perr_q <= 1'b1;
    else if (perr_clr_i)           perr_q <= 1'b0;
  end
  assign perr_o = perr_q;
endmodule

// File: rtl/pt_checker.sv
module pt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pix_valid_i,
  input logic frame_start_i,
  input logic arm_set_i,
  input logic perr_clr_i,
  input logic armed_o,
  input logic perr_o,
  input logic word_valid_o,
  input logic capt_now,
  input logic pix_perr
);
  AST_WORD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o); // R8
  AST_WORD_AFTER_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(capt_now)); // R8
  AST_PERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capt_now && pix_perr |=> perr_o); // R5
  AST_PERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o && !perr_clr_i |=> perr_o); // R5
  AST_PERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_clr_i && !(capt_now && pix_perr) |=> !perr_o); // R5
  AST_ARM_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i && frame_start_i && !arm_set_i |=> !armed_o); // R6
  AST_ARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_set_i |=> armed_o); // R7
  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |-> !capt_now); // R9
endmodule

bind pix_thresh_unit pt_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pix_valid_i   (pix_valid_i),
  .frame_start_i (frame_start_i),
  .arm_set_i     (arm_set_i),
  .perr_clr_i    (perr_clr_i),
  .armed_o       (armed_o),
  .perr_o        (perr_o),
  .word_valid_o  (word_valid_o),
  .capt_now      (capt_now),
  .pix_perr      (pix_perr)
);

// File: tb/tb_pix_thresh_unit.sv
module tb_pix_thresh_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0, frame_start = 1'b0, arm_set = 1'b0;
  logic [11:0] pix_data = '0;
  logic [9:0]  pix_col = '0;
  logic [15:0] bias_word = '0;
  logic        thr_we = 1'b0, perr_clr = 1'b0;
  logic [1:0]  thr_sel = '0;
  logic [13:0] thr_data = '0;
  logic        armed, perr, word_valid;
  logic [31:0] word_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_thresh_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pix_valid), .frame_start_i(frame_start),
    .pix_data_i(pix_data), .pix_col_i(pix_col), .bias_word_i(bias_word),
    .arm_set_i(arm_set), .thr_we_i(thr_we), .thr_sel_i(thr_sel), .thr_data_i(thr_data),
    .perr_clr_i(perr_clr), .armed_o(armed), .perr_o(perr),
    .word_valid_o(word_valid), .word_data_o(word_data)
  );

  int n_cmp = 0, n_fail = 0, n_words = 0;
  logic [31:0] last_word = '0;
  bit done = 0;

  // reference model state
  bit          m_armed, m_capt, m_perr, m_wv;
  int          m_cnt;
  logic [31:0] m_acc, m_wd;
  logic [13:0] m_thr [4];

  task automatic cmp(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_capt = 0; m_perr = 0; m_wv = 0; m_cnt = 0;
      m_acc = '0; m_wd = '0;
      for (int i = 0; i < 4; i++) m_thr[i] = '0;
    end else begin : step
      bit st, cp, err;
      int d, th, g;
      m_wv = 0;
      st = pix_valid && frame_start;
      cp = 0;
      err = 0;
      if (pix_valid) cp = st ? m_armed : m_capt;
      if (st) begin
        m_capt = m_armed;
        m_armed = arm_set;
        m_cnt = 0;
      end else if (arm_set) m_armed = 1;
      if (cp) begin
        err = ($countones({bias_word[12], bias_word[11:0]}) % 2 == 0) || bias_word[15];
        g = int'(pix_col) / 256;
        th = int'(m_thr[g]);
        if (th >= 8192) th -= 16384;
        d = int'(pix_data) - int'(bias_word[11:0]);
        m_acc[m_cnt] = (d > th);
        m_cnt++;
        if (m_cnt == 32) begin
          m_wv = 1; m_wd = m_acc; m_cnt = 0;
        end
      end
      if (err) m_perr = 1;
      else if (perr_clr) m_perr = 0;
      if (thr_we) m_thr[thr_sel] = thr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R6 armed", {31'b0, armed}, {31'b0, m_armed});
      cmp("R5 perr", {31'b0, perr}, {31'b0, m_perr});
      cmp("R8 word_valid", {31'b0, word_valid}, {31'b0, m_wv});
      if (m_wv) cmp("R8 word_data", word_data, m_wd);
      if (word_valid) begin
        n_words++;
        last_word = word_data;
      end
    end
  end

  task automatic drive_idle();
    pix_valid = 0; frame_start = 1'($urandom); pix_data = 12'($urandom);
    pix_col = 10'($urandom); bias_word = 16'($urandom);
    arm_set = 0; thr_we = 0; perr_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive_idle();
    end
  endtask

  task automatic pix(input logic st, input int col, input int p, input logic [15:0] bw,
                     input logic arm = 1'b0, input logic clr = 1'b0);
    @(negedge clk);
    pix_valid = 1; frame_start = st; pix_col = 10'(col); pix_data = 12'(p);
    bias_word = bw; arm_set = arm; perr_clr = clr; thr_we = 0;
  endtask

  task automatic arm_pulse();
    @(negedge clk);
    drive_idle();
    arm_set = 1;
  endtask

  task automatic clr_pulse();
    @(negedge clk);
    drive_idle();
    perr_clr = 1;
  endtask

  task automatic thr_write(input int sel, input logic [13:0] v);
    @(negedge clk);
    drive_idle();
    thr_we = 1; thr_sel = 2'(sel); thr_data = v;
  endtask

  // 32 pixels, even index 106 / odd 105 over bias 100
  task automatic frame_alt(input int col0, input logic st);
    for (int i = 0; i < 32; i++) pix(st && i == 0, col0 + i, (i % 2 == 0) ? 106 : 105, 16'd100);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin : main
    int w0;
    drive_idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    drive_idle();
    cmp("R1 armed after reset", {31'b0, armed}, 32'd0);
    cmp("R1 perr after reset", {31'b0, perr}, 32'd0);
    cmp("R1 word_valid after reset", {31'b0, word_valid}, 32'd0);

    // R1: thresholds reset to zero -> diff 1 is above, diff 0 is not
    arm_pulse();
    w0 = n_words;
    for (int i = 0; i < 32; i++) pix(i == 0, i, (i < 16) ? 101 : 100, 16'd100);
    idle(2);
    cmp("R1 zero threshold word count", n_words - w0, 1);
    cmp("R1 zero threshold word", last_word, 32'h0000FFFF);

    // R2: equal is not above, one more is
    thr_write(0, 14'd5);
    arm_pulse();
    w0 = n_words;
    frame_alt(0, 1);
    idle(2);
    cmp("R2 strict greater word", last_word, 32'h55555555);
    cmp("R2 word count", n_words - w0, 1);

    // R3: group select by column bits 9:8, negative threshold
    thr_write(1, 14'h3FFD);
    thr_write(2, 14'd100);
    arm_pulse();
    for (int i = 0; i < 32; i++) pix(i == 0, 256 + i, (i < 16) ? 98 : 97, 16'd100);
    idle(2);
    cmp("R3 group1 negative threshold", last_word, 32'h0000FFFF);
    for (int i = 0; i < 32; i++) pix(0, 512 + i, (i % 2) ? 201 : 200, 16'd100);
    idle(2);
    cmp("R3 group2 threshold", last_word, 32'hAAAAAAAA);

    // R4 / R5: parity and sticky flag
    arm_pulse();
    w0 = n_words;
    pix(1, 0, 200, 16'd100 | 16'h1000);
    idle(1);
    cmp("R4 even ones flagged", {31'b0, perr}, 32'd1);
    pix(0, 1, 200, 16'd100);
    idle(1);
    cmp("R5 sticky hold", {31'b0, perr}, 32'd1);
    clr_pulse();
    idle(1);
    cmp("R5 clear", {31'b0, perr}, 32'd0);
    pix(0, 2, 200, 16'd100 | 16'h8000);
    idle(1);
    cmp("R4 error bit flagged", {31'b0, perr}, 32'd1);
    clr_pulse();
    pix(0, 3, 200, 16'd100 | 16'h6000);
    idle(1);
    cmp("R4 bits 14:13 ignored", {31'b0, perr}, 32'd0);
    pix(0, 4, 200, 16'd3 | 16'h1000);
    idle(1);
    cmp("R4 parity bit completes odd", {31'b0, perr}, 32'd0);
    pix(0, 5, 200, 16'd100 | 16'h1000, 1'b0, 1'b1);
    idle(1);
    cmp("R5 set wins over clear", {31'b0, perr}, 32'd1);
    for (int i = 6; i < 32; i++) pix(0, i, 200, 16'd100);
    idle(2);
    cmp("R5 failing pixel keeps bit", last_word, 32'hFFFFFFFF);
    cmp("R5 word count", n_words - w0, 1);
    clr_pulse();

    // R6: unarmed frame dropped
    idle(1);
    cmp("R6 not armed", {31'b0, armed}, 32'd0);
    w0 = n_words;
    for (int i = 0; i < 40; i++) pix(i == 0, i, 4000, 16'd100 | 16'h1000);
    idle(2);
    cmp("R6 no words from dropped frame", n_words - w0, 0);
    cmp("R6 no parity from dropped frame", {31'b0, perr}, 32'd0);

    // R7: arm with frame start arms next frame
    w0 = n_words;
    pix(1, 0, 4000, 16'd100, 1'b1);
    idle(1);
    cmp("R7 armed after start+arm", {31'b0, armed}, 32'd1);
    for (int i = 1; i < 32; i++) pix(0, i, 4000, 16'd100);
    idle(1);
    cmp("R7 dropped frame silent", n_words - w0, 0);
    frame_alt(0, 1);
    idle(2);
    cmp("R7 next frame captured", n_words - w0, 1);
    cmp("R7 next frame word", last_word, 32'h55555555);
    cmp("R7 flag consumed", {31'b0, armed}, 32'd0);

    // R8: restart discards partial word
    arm_pulse();
    w0 = n_words;
    for (int i = 0; i < 10; i++) pix(i == 0, i, 4000, 16'd100);
    arm_pulse();
    frame_alt(0, 1);
    idle(2);
    cmp("R8 partial discarded count", n_words - w0, 1);
    cmp("R8 restart word", last_word, 32'h55555555);

    // R9: invalid cycles ignored even with frame_start high
    arm_pulse();
    w0 = n_words;
    for (int i = 0; i < 32; i++) begin
      pix(i == 0, i, (i % 2 == 0) ? 106 : 105, 16'd100);
      idle(1);
    end
    idle(2);
    cmp("R9 gaps ignored count", n_words - w0, 1);
    cmp("R9 gaps ignored word", last_word, 32'h55555555);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule